// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects single-cycle event pulses from hardware sources into a bank of sticky status bits. It combines them with a mask into one level-sensitive interrupt line. Software reaches the block through a small word-addressed register port. It can read the status and the mask, and it clears status bits by writing ones to them. The number of sources is set by the parameter `NSRC`.

The mask has no direct write path. Software lowers mask bits through an unmask port and raises them through a mask-set port. Each of these ports acts only on the bit positions that carry a one in the written word, so drivers that share the block can each change their own sources without a read-modify-write race. After reset every source is masked. The interrupt output is taken from a register, so it follows the pending state one clock later.

Register map, by word address on `addr`: 0 = status (read, write-one-to-clear), 1 = mask (read only), 2 = unmask port (write only), 3 = mask-set port (write only).

Top module: `irq_stat_ctl`

## Requirements
- R1: While reset is held and after it is released with no other activity, status reads 0, mask reads all ones, and `irq` is 0.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k at the following clock edge, and the bit holds until it is cleared.
- R3: A write to address 0 clears each status bit whose `wdata` bit is 1 and leaves each status bit whose `wdata` bit is 0 unchanged.
- R4: If an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R5: A write to address 1 (mask) leaves the mask unchanged.
- R6: A write to address 2 clears each mask bit whose `wdata` bit is 1 and leaves the other mask bits unchanged.
- R7: A write to address 3 sets each mask bit whose `wdata` bit is 1 and leaves the other mask bits unchanged.
- R8: Reads of address 2 and address 3 return 0, whatever was written to them.
- R9: `irq` equals the OR over k of (status[k] AND NOT mask[k]), taken from the state one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NSRC | One-cycle event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Read data for `addr`, combinational |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with `NSRC` = 3. With that width every status pattern can be swept against every mask pattern, and every clear pattern against every prior status. Event-against-clear collisions can also be swept over all combinations. This gives exhaustive coverage of the pending function, write-one-to-clear, the set-over-clear priority and the two mask ports. It also checks the one-clock lag of the interrupt.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS  = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_UNMASK  = 2'd2,
    SEL_MASKSET = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/istat_status.sv
module istat_status #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_wr_i,
  input  logic [NSRC-1:0] clr_data_i,
  output logic [NSRC-1:0] st_o
);
  logic [NSRC-1:0] set_hit;
  logic [NSRC-1:0] clr_hit;
  logic [NSRC-1:0] st_next;

  function automatic logic [NSRC-1:0] f_next(input logic [NSRC-1:0] st,
                                              input logic [NSRC-1:0] set,
                                              input logic [NSRC-1:0] clr);
    return set | (st & ~clr);
  endfunction

  assign set_hit = set_i;
  assign clr_hit = clr_wr_i ? clr_data_i : '0;
  assign st_next = f_next(st_o, set_hit, clr_hit);

  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) st_o[k] <= 1'b0;
      else        st_o[k] <= st_next[k];
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[k] |=> st_o[k]);

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[k] && !set_hit[k]) |=> !st_o[k]);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_o[k] && !clr_hit[k]) |=> st_o[k]);
  end
endmodule

// File: rtl/istat_mask.sv
module istat_mask #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            unmask_wr_i,
  input  logic            maskset_wr_i,
  input  logic [NSRC-1:0] data_i,
  output logic [NSRC-1:0] mask_o
);
  logic [NSRC-1:0] mask_next;
  logic            port_touch;

  function automatic logic [NSRC-1:0] f_mask(input logic [NSRC-1:0] m,
                                              input logic            en,
                                              input logic            dis,
                                              input logic [NSRC-1:0] d);
    logic [NSRC-1:0] r;
    r = m;
    if (en)  r = r & ~d;
    if (dis) r = r | d;
    return r;
  endfunction

  assign port_touch = unmask_wr_i | maskset_wr_i;
  assign mask_next  = f_mask(mask_o, unmask_wr_i, maskset_wr_i, data_i);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_o <= '1;
    else        mask_o <= mask_next;
  end

  // R6
  unmask_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_wr_i |=> ((mask_o & $past(data_i)) == '0));

  // R7
  maskset_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maskset_wr_i |=> ((mask_o & $past(data_i)) == $past(data_i)));

  // R5
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_touch |=> $stable(mask_o));
endmodule

// File: rtl/istat_irq.sv
module istat_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] st_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            irq_o
);
  logic pend;

  function automatic logic f_pending(input logic [NSRC-1:0] s,
                                     input logic [NSRC-1:0] m);
    return |(s & ~m);
  endfunction

  assign pend = f_pending(st_i, mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend;
  end

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> irq_o);

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !irq_o);
endmodule

// File: rtl/irq_stat_ctl.sv
module irq_stat_ctl
  import irq_stat_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   rdata,
  output logic              irq
);
  reg_sel_e        sel;
  logic            wr_status;
  logic            wr_unmask;
  logic            wr_maskset;
  logic [NSRC-1:0] st_q;
  logic [NSRC-1:0] mask_q;

  assign sel        = reg_sel_e'(addr);
  assign wr_status  = wr_en && (sel == SEL_STATUS);
  assign wr_unmask  = wr_en && (sel == SEL_UNMASK);
  assign wr_maskset = wr_en && (sel == SEL_MASKSET);

  istat_status #(.NSRC(NSRC)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_i),
    .clr_wr_i   (wr_status),
    .clr_data_i (wdata),
    .st_o       (st_q)
  );

  istat_mask #(.NSRC(NSRC)) u_mask (
    .clk          (clk),
    .rst_n        (rst_n),
    .unmask_wr_i  (wr_unmask),
    .maskset_wr_i (wr_maskset),
    .data_i       (wdata),
    .mask_o       (mask_q)
  );

  istat_irq #(.NSRC(NSRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .st_i   (st_q),
    .mask_i (mask_q),
    .irq_o  (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata = st_q;
      SEL_MASK:   rdata = mask_q;
      default:    rdata = '0;
    endcase
  end

  // R8
  port_readzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_UNMASK || sel == SEL_MASKSET) |-> (rdata == '0));

  // R5
  mask_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_MASK) |=> $stable(mask_q));
endmodule

// File: tb/irq_stat_ctl_test.sv
`timescale 1ns/1ps
module irq_stat_ctl_test;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_stat_ctl #(.NSRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic collide(input logic [N-1:0] e, input logic [N-1:0] c);
    @(negedge clk); evt_i = e; wr_en = 1'b1; addr = 2'd0; wdata = c;
    @(negedge clk); evt_i = '0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic set_mask(input logic [N-1:0] m);
    wr(2'd3, '1);
    wr(2'd2, ~m);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(2'd0, v); chk("R1 status in reset", v, 0);
    rd(2'd1, v); chk("R1 mask in reset", v, 7);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R1 status after reset", v, 0);
    rd(2'd1, v); chk("R1 mask after reset", v, 7);
    chk("R1 irq after reset", irq, 0);

    // R2 R6 R7 R9 sweep status x mask
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 8; s++) begin
        set_mask(m[N-1:0]);
        wr(2'd0, '1);
        @(negedge clk);
        pulse(s[N-1:0]);
        chk("R9 irq lags one clock", irq, 0);
        rd(2'd0, v); chk("R2 status set by events", v, s);
        rd(2'd1, v); chk("R6 R7 mask via ports", v, m);
        @(negedge clk);
        chk("R9 irq pending", irq, ((s & ~m) & 7) != 0 ? 1 : 0);
      end
    end

    // R3 write-one-to-clear sweep
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 8; c++) begin
        wr(2'd0, '1);
        pulse(s[N-1:0]);
        wr(2'd0, c[N-1:0]);
        rd(2'd0, v); chk("R3 w1c", v, s & ~c & 7);
      end
    end

    // R4 set wins over clear
    for (int e = 0; e < 8; e++) begin
      for (int c = 0; c < 8; c++) begin
        wr(2'd0, '1);
        pulse(3'b101);
        collide(e[N-1:0], c[N-1:0]);
        rd(2'd0, v); chk("R4 set over clear", v, ((5 & ~c) | e) & 7);
      end
    end

    // R5 direct mask write ignored
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 8; d++) begin
        set_mask(m[N-1:0]);
        wr(2'd1, d[N-1:0]);
        rd(2'd1, v); chk("R5 mask direct write", v, m);
      end
    end

    // R6 R7 incremental
    set_mask(3'b111);
    wr(2'd2, 3'b001); rd(2'd1, v); chk("R6 unmask bit0", v, 6);
    wr(2'd2, 3'b100); rd(2'd1, v); chk("R6 unmask bit2", v, 2);
    wr(2'd2, 3'b000); rd(2'd1, v); chk("R6 unmask none", v, 2);
    wr(2'd3, 3'b001); rd(2'd1, v); chk("R7 maskset bit0", v, 3);
    wr(2'd3, 3'b000); rd(2'd1, v); chk("R7 maskset none", v, 3);

    // R8 port readback
    wr(2'd2, 3'b111); rd(2'd2, v); chk("R8 unmask reads zero", v, 0);
    wr(2'd3, 3'b101); rd(2'd3, v); chk("R8 maskset reads zero", v, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule